// File: doc/BRIEF.md
# Frequency-Coded Command Pulse Encoder

This block puts several discrete control commands, such as stop, start and reset, onto one serial line that feeds an optical transmitter. It does not send a code word. Each command has its own pulse-train frequency, and the receiver tells the commands apart by measuring the period of that train.

Each request line first passes through its own glitch filter. A fixed-priority selector then picks one winner from the filtered requests. The winner gates a divider that produces the command's pulse train with a 50% duty cycle. Only one train is ever on the line. When the winner changes or goes away, the divider restarts from zero and the line goes low, so no piece of the old frequency leaks out. The 6-bit divider count is brought out for observation.

Top module: `cmd_pulse_enc`

## Requirements
- R1: An active-low `rst_ni` asynchronously forces `line_o` low and `cnt_o` to zero, and clears every filter, without waiting for a clock edge.
- R2: A request counts only after it has been sampled high on FILT_LEN consecutive rising edges (default 16). A shorter high pulse leaves `line_o` low and `cnt_o` zero.
- R3: When a request is sampled low, its filter count restarts. The next high phase again needs FILT_LEN consecutive high samples.
- R4: Priority is fixed by bit index. Filtered `req_i[0]` always wins, `req_i[1]` wins only when bit 0 is inactive, and `req_i[2]` wins only when bits 0 and 1 are both inactive. The stop command belongs on bit 0. The selection is combinational from the filtered requests and adds no clock of latency.
- R5: While command k stays selected, `cnt_o` steps 0, 1, …, DIV_TAB[k]-1 and wraps. `line_o` is low while the count is below DIV_TAB[k]/2 and high otherwise. The defaults are 8, 16 and 32 clocks per period for bits 0, 1 and 2.
- R6: On the first rising edge at which the selected command differs from the one in service, `cnt_o` becomes 0 and `line_o` becomes low. The new train starts from that point.
- R7: While no command is selected, `cnt_o` stays 0 and `line_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| req_i | input | 3 | Raw command requests; bit 0 has the highest priority |
| line_o | output | 1 | Frequency-coded serial output |
| cnt_o | output | 6 | Divider count, for observation |

## Verification
Two events can fall on the same edge. A higher-priority filter can complete its interval at the same edge where the divider of the command in service would otherwise wrap or toggle the line. The bench provokes this by raising the higher-priority request while a lower command's train is running, with the raise timed so that its filter completes near a period boundary. It also raises all requests in one cycle. A behavioural reference model computes, on every clock, the count and line level the requirements demand. The bench judges whether the switch clears the count and line on exactly that edge, rather than emitting one more step of the old train.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam int unsigned NUM_CMD = 3;
  typedef logic [NUM_CMD-1:0] cmd_vec_t;

  // lowest index wins
  function automatic cmd_vec_t pick_first(cmd_vec_t v);
    cmd_vec_t r;
    logic     taken;
    r     = '0;
    taken = 1'b0;
    for (int k = 0; k < NUM_CMD; k++) begin
      if (v[k] && !taken) begin
        r[k]  = 1'b1;
        taken = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/cpe_filter.sv
module cpe_filter #(
  parameter int unsigned FILT_LEN = 16,
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  logic [CW-1:0] run_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (!raw_i) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (!filt_q) begin
      if (run_q == CW'(FILT_LEN - 1)) filt_q <= 1'b1;
      else                            run_q  <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/cpe_prio.sv
module cpe_prio
  import cpe_pkg::*;
(
  input  cmd_vec_t filt_i,
  output cmd_vec_t grant_o
);
  assign grant_o = pick_first(filt_i);
endmodule

// File: rtl/cpe_divider.sv
module cpe_divider
  import cpe_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned DIV_TAB [NUM_CMD] = '{8, 16, 32}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_vec_t         grant_i,
  output cmd_vec_t         cur_o,
  output logic             line_o,
  output logic [CNT_W-1:0] cnt_o
);
  cmd_vec_t         cur_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             line_q, line_nx;
  logic [CNT_W:0]   div_cur;

  always_comb begin
    div_cur = '0;
    for (int k = 0; k < NUM_CMD; k++) begin
      if (cur_q[k]) div_cur = (CNT_W + 1)'(DIV_TAB[k]);
    end
  end

  always_comb begin
    if (({1'b0, cnt_q} + 1'b1) == div_cur) cnt_nx = '0;
    else                                   cnt_nx = cnt_q + 1'b1;
    line_nx = ({1'b0, cnt_nx} >= (div_cur >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else if (grant_i != cur_q) begin
      // drop any partial pulse of the old command
      cur_q  <= grant_i;
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else if (|cur_q) begin
      cnt_q  <= cnt_nx;
      line_q <= line_nx;
    end else begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end
  end

  assign cur_o  = cur_q;
  assign line_o = line_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cmd_pulse_enc.sv
module cmd_pulse_enc
  import cpe_pkg::*;
#(
  parameter int unsigned FILT_LEN = 16,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned DIV_TAB [NUM_CMD] = '{8, 16, 32}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CMD-1:0] req_i,
  output logic               line_o,
  output logic [CNT_W-1:0]   cnt_o
);
  cmd_vec_t filt;
  cmd_vec_t grant;
  cmd_vec_t cur;

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_filt
    cpe_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (req_i[i]),
      .filt_o (filt[i])
    );
  end

  cpe_prio u_prio (
    .filt_i  (filt),
    .grant_o (grant)
  );

  cpe_divider #(.CNT_W(CNT_W), .DIV_TAB(DIV_TAB)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grant_i (grant),
    .cur_o   (cur),
    .line_o  (line_o),
    .cnt_o   (cnt_o)
  );
endmodule

// File: rtl/cpe_checker.sv
module cpe_checker
  import cpe_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NUM_CMD-1:0] req_i,
  input cmd_vec_t         filt,
  input cmd_vec_t         grant,
  input cmd_vec_t         cur,
  input logic             line_o,
  input logic [CNT_W-1:0] cnt_o
);
  a_r4_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  a_r4_top_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt[0] |-> grant[0]);

  a_r6_switch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant != cur) |=> (cnt_o == '0) && !line_o);

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == '0) |-> (cnt_o == '0) && !line_o);

  a_r5_line_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> (cur != '0));

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_req
    a_r2_rise_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(filt[i]) |-> $past(req_i[i]));
    a_r3_drop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[i] |=> !filt[i]);
  end
endmodule

bind cmd_pulse_enc cpe_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .filt   (filt),
  .grant  (grant),
  .cur    (cur),
  .line_o (line_o),
  .cnt_o  (cnt_o)
);

// File: tb/cmd_pulse_enc_bench.sv
module cmd_pulse_enc_bench;
  localparam int FILT = 16;
  localparam int DIVS [3] = '{8, 16, 32};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic       line;
  logic [5:0] cnt;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    running = 0;
  string tag = "R1";

  // reference model state
  int run_m [3];
  bit filt_m [3];
  int cur_m;
  int cnt_m;
  bit line_m;

  always #4 clk = ~clk;

  cmd_pulse_enc u_cmd_pulse_enc (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .line_o (line),
    .cnt_o  (cnt)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin run_m[i] = 0; filt_m[i] = 0; end
      cur_m = -1; cnt_m = 0; line_m = 0;
    end else begin
      int g;
      g = filt_m[0] ? 0 : filt_m[1] ? 1 : filt_m[2] ? 2 : -1;
      if (g != cur_m) begin
        cur_m = g; cnt_m = 0; line_m = 0;
      end else if (cur_m >= 0) begin
        cnt_m  = (cnt_m + 1) % DIVS[cur_m];
        line_m = (cnt_m >= DIVS[cur_m] / 2);
      end else begin
        cnt_m = 0; line_m = 0;
      end
      for (int i = 0; i < 3; i++) begin
        if (!req[i]) begin run_m[i] = 0; filt_m[i] = 0; end
        else if (!filt_m[i]) begin
          run_m[i]++;
          if (run_m[i] == FILT) filt_m[i] = 1;
        end
      end
    end
  end

  task automatic chk(input string t);
    n_vec++;
    if (line !== line_m || cnt !== 6'(cnt_m)) begin
      n_bad++;
      $display("FAIL %s: line=%0b cnt=%0d expected line=%0b cnt=%0d at %0t",
               t, line, cnt, line_m, cnt_m, $time);
    end
  endtask

  always @(negedge clk) if (running && rst_n) chk(tag);

  task automatic hold(input logic [2:0] r, input int n);
    @(negedge clk);
    req = r;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1");
    rst_n = 1'b1;
    running = 1;
    repeat (4) @(negedge clk);
    tag = "R2"; hold(3'b001, 10); hold(3'b000, 5);
    tag = "R2"; hold(3'b100, FILT - 1); hold(3'b000, 5);
    tag = "R3"; hold(3'b010, 12); hold(3'b000, 1); hold(3'b010, 12);
    hold(3'b000, 1); hold(3'b010, 60);
    tag = "R7"; hold(3'b000, 20);
    tag = "R5"; hold(3'b100, 120);
    tag = "R5"; hold(3'b001, 60);
    tag = "R7"; hold(3'b000, 10);
    tag = "R4"; hold(3'b100, 40); hold(3'b110, 50); hold(3'b111, 50);
    tag = "R6"; hold(3'b110, 45); hold(3'b100, 45); hold(3'b000, 6);
    tag = "R4"; hold(3'b111, 50); hold(3'b000, 4);
    for (int off = 0; off < 8; off++) begin
      tag = "R6"; hold(3'b100, 20 + off); hold(3'b101, 30);
    end
    hold(3'b010, 30); hold(3'b011, 30);
    // async clear mid-train
    tag = "R1";
    #1 rst_n = 1'b0;
    #1;
    chk("R1");
    @(negedge clk); chk("R1");
    rst_n = 1'b1;
    hold(3'b010, 40); hold(3'b000, 4);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule